// File: doc/BRIEF.md
# Serial Transmit Queue with Fill-Level Interrupt

This block sits between a processor bus and a serial shifter. Software writes bytes into a small byte-wide queue. The shifter pulls them one at a time into a holding buffer, and from there it sends them out. A single 32-bit control word configures the interrupt and carries two self-clearing commands: one empties the queue, the other discards the byte in the holding buffer. The block reports a 3-bit fill level. It raises a one-cycle transmit interrupt request when, after the fill level moves, the level starts to satisfy the programmed condition.

The channel runs in one of two duplex modes, chosen by an input pin. The mode sets how many bytes the queue accepts and how the 2-bit threshold code is read. A compare-mode bit selects whether the interrupt condition is "level equals threshold" or "level at or below threshold". The control word returns to all zeros whenever the channel is disabled, or whenever the chip idles with channel operation in idle turned off.

Top module: `sertx_fifo`

## Requirements
- R1: `reg_rdata` returns the compare-mode bit at bit 6 and the threshold code at bits 1:0. Every other bit reads 0, including the command bits 8 and 7.
- R2: A register write with bit 7 set makes the fill level 0, clears `overrun` and resets both pointers, all at the next edge. A push in the same cycle is dropped. A write with bit 7 at 0 leaves the queue untouched.
- R3: A register write with bit 8 set makes `hold_full` and `hold_data` 0 at the next edge and leaves the fill level alone. A pop in the same cycle is ignored.
- R4: Bytes leave in the order they were pushed. Each accepted push raises `tx_level` by one. Each accepted pop lowers it by one and loads the head byte into `hold_data` with `hold_full`=1. Both results are visible after the same edge.
- R5: The queue holds 4 bytes when `full_duplex`=0 and 2 bytes when it is 1. A push at that limit is dropped and sets `overrun`, which stays 1 until a queue clear.
- R6: A pop while `tx_level`=0 leaves `hold_data`, `hold_full` and `tx_level` unchanged.
- R7: With `full_duplex`=0, threshold codes 0, 1, 2 and 3 stand for levels 0, 1, 2 and 3.
- R8: With `full_duplex`=1, threshold codes 0 and 2 stand for level 0, and codes 1 and 3 stand for level 1.
- R9: Compare-mode bit 0 means the condition is level == threshold. Bit 1 means level <= threshold.
- R10: `tx_irq` is high for exactly the one cycle after a push, pop or queue clear that moves the condition from false to true. It is not raised again while the condition stays true.
- R11: While `ch_enable`=0, or while `idle_mode`=1 with `idle_keep_run`=0, the control word is forced to 0 at each edge, and register writes (including commands) are ignored.
- R12: A push and a pop in the same cycle both take effect, judged against the level before that cycle. The level is then unchanged, and the old head byte moves to `hold_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | 1 | Serial channel enable |
| idle_mode | input | 1 | Chip is in idle mode |
| idle_keep_run | input | 1 | Channel keeps operating during idle |
| full_duplex | input | 1 | 1 = full-duplex, 0 = half-duplex |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| push_valid | input | 1 | Push a byte from the CPU side |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Shifter pops the head into the holding buffer |
| hold_data | output | 8 | Holding buffer byte |
| hold_full | output | 1 | Holding buffer holds a byte |
| tx_level | output | 3 | Queue fill level |
| overrun | output | 1 | Sticky push-when-full flag |
| tx_irq | output | 1 | Transmit interrupt request pulse |

## Verification
Every result is due exactly one edge after the cycle that caused it: the fill level, the holding buffer, `overrun`, the control word readback and the interrupt pulse all appear together. The bench drives inputs on the falling edge. A behavioural queue model advances on the rising edge. All outputs are compared at the next falling edge, so every compare lands one edge after its stimulus. Directed sequences check each result at that same falling edge, and an interrupt check also looks one cycle later to confirm the pulse has dropped.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned CSR_W    = 32;
    localparam int unsigned LVL_W    = 3;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned BUFCLR_B = 8;
    localparam int unsigned QCLR_B   = 7;
    localparam int unsigned CMP_B    = 6;

    typedef enum logic {
        CMP_EQUAL = 1'b0,
        CMP_AT_OR_BELOW = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        cmp_mode_e  cmp;
        logic [1:0] code;
    } txcfg_t;

    typedef struct packed {
        logic q_clear;
        logic buf_clear;
    } txcmd_t;

    // Threshold level selected by a code under the current duplex mode
    function automatic logic [LVL_W-1:0] thr_of(input logic [1:0] code, input logic fdx);
        logic [LVL_W-1:0] t;
        if (fdx) t = LVL_W'(code[0]);
        else     t = LVL_W'(code);
        return t;
    endfunction

    // Whether a fill level satisfies the programmed condition
    function automatic logic cond_met(input logic [LVL_W-1:0] lvl, input txcfg_t cfg, input logic fdx);
        logic [LVL_W-1:0] t;
        t = thr_of(cfg.code, fdx);
        if (cfg.cmp == CMP_AT_OR_BELOW) return (lvl <= t);
        return (lvl == t);
    endfunction

endpackage

// File: rtl/sertx_cfg.sv
module sertx_cfg
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_live,
    input  logic             reg_wr,
    input  logic [CSR_W-1:0] reg_wdata,
    output txcfg_t           cfg,
    output txcmd_t           cmd,
    output logic [CSR_W-1:0] reg_rdata
);

    txcfg_t cfg_q;
    logic   wr_ok;

    assign wr_ok = reg_wr && cfg_live;

    always_ff @(posedge clk) begin
        if (rst || !cfg_live) begin
            cfg_q <= '{cmp: CMP_EQUAL, code: 2'b00};
        end else if (wr_ok) begin
            cfg_q.cmp  <= cmp_mode_e'(reg_wdata[CMP_B]);
            cfg_q.code <= reg_wdata[1:0];
        end
    end

    always_comb begin
        cmd.q_clear   = wr_ok && reg_wdata[QCLR_B];
        cmd.buf_clear = wr_ok && reg_wdata[BUFCLR_B];
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[CMP_B]   = cfg_q.cmp;
        reg_rdata[1:0]     = cfg_q.code;
    end

    assign cfg = cfg_q;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[CSR_W-1:BUFCLR_B+1], reg_wdata[CMP_B-1:2]};

endmodule

// File: rtl/sertx_store.sv
module sertx_store
    import sertx_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned DW    = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  txcmd_t           cmd,
    input  logic             fdx,
    input  logic             push_valid,
    input  logic [DW-1:0]    push_data,
    input  logic             pop_req,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_nxt,
    output logic             step_evt,
    output logic [DW-1:0]    hold_data,
    output logic             hold_full,
    output logic             overrun
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] CAP_HALF = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] CAP_FULL = LVL_W'(DEPTH / 2);

    logic [DW-1:0]    slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] lvl_q, cap;
    logic             take_push, take_pop, drop_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        cap       = fdx ? CAP_FULL : CAP_HALF;
        take_push = push_valid && !cmd.q_clear && (lvl_q < cap);
        take_pop  = pop_req && !cmd.q_clear && !cmd.buf_clear && (lvl_q != '0);
        drop_push = push_valid && !cmd.q_clear && !take_push;
        if (cmd.q_clear) level_nxt = '0;
        else level_nxt = lvl_q + LVL_W'(take_push) - LVL_W'(take_pop);
        step_evt  = cmd.q_clear || take_push || take_pop;
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) slot[i] <= '0;
                else if (take_push && (wr_ptr == PTR_W'(i))) slot[i] <= push_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || cmd.q_clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            if (take_push) wr_ptr <= bump(wr_ptr);
            if (take_pop)  rd_ptr <= bump(rd_ptr);
            lvl_q <= level_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.buf_clear) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (take_pop) begin
            hold_data <= slot[rd_ptr];
            hold_full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.q_clear) overrun <= 1'b0;
        else if (drop_push)     overrun <= 1'b1;
    end

    assign level = lvl_q;

endmodule

// File: rtl/sertx_irq.sv
module sertx_irq
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  txcfg_t           cfg,
    input  logic             fdx,
    input  logic             step_evt,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_nxt,
    output logic             irq
);

    logic met_now, met_nxt;

    always_comb begin
        met_now = cond_met(level, cfg, fdx);
        met_nxt = cond_met(level_nxt, cfg, fdx);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= step_evt && met_nxt && !met_now;
    end

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo
    import sertx_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_enable,
    input  logic              idle_mode,
    input  logic              idle_keep_run,
    input  logic              full_duplex,
    input  logic              reg_wr,
    input  logic [CSR_W-1:0]  reg_wdata,
    output logic [CSR_W-1:0]  reg_rdata,
    input  logic              push_valid,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] hold_data,
    output logic              hold_full,
    output logic [LVL_W-1:0]  tx_level,
    output logic              overrun,
    output logic              tx_irq
);

    txcfg_t           cfg;
    txcmd_t           cmd;
    logic             cfg_live;
    logic [LVL_W-1:0] lvl_nxt;
    logic             evt;

    assign cfg_live = ch_enable && !(idle_mode && !idle_keep_run);

    sertx_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_live  (cfg_live),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cfg       (cfg),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    sertx_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .fdx        (full_duplex),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop_req    (pop_req),
        .level      (tx_level),
        .level_nxt  (lvl_nxt),
        .step_evt   (evt),
        .hold_data  (hold_data),
        .hold_full  (hold_full),
        .overrun    (overrun)
    );

    sertx_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .fdx       (full_duplex),
        .step_evt  (evt),
        .level     (tx_level),
        .level_nxt (lvl_nxt),
        .irq       (tx_irq)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ch_enable,
    input logic              reg_wr,
    input logic [CSR_W-1:0]  reg_wdata,
    input logic [CSR_W-1:0]  reg_rdata,
    input logic              pop_req,
    input logic [BYTE_W-1:0] hold_data,
    input logic [LVL_W-1:0]  tx_level,
    input logic              overrun,
    input logic              tx_irq
);

    AST_RDATA_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~32'h0000_0043) == 32'h0) else $error("reserved bits set"); // R1

    AST_QCLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && ch_enable && reg_rdata == 32'h0 && reg_wdata[QCLR_B] && $past(ch_enable))
        |=> tx_level == '0) else $error("queue clear left data"); // R2

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LVL_W'(DEPTH)) else $error("level above depth"); // R5

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !reg_wr) |=> overrun) else $error("overrun dropped"); // R5

    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop_req && tx_level == '0 && !reg_wr) |=> $stable(hold_data)) else $error("empty pop moved data"); // R6

    AST_IRQ_LEVEL_MOVED: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> tx_level != $past(tx_level)) else $error("irq without level change"); // R10

    AST_CFG_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !ch_enable |=> reg_rdata == 32'h0) else $error("config kept while disabled"); // R11

endmodule

bind sertx_fifo sertx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_enable (ch_enable),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pop_req   (pop_req),
    .hold_data (hold_data),
    .tx_level  (tx_level),
    .overrun   (overrun),
    .tx_irq    (tx_irq)
);

// File: tb/sertx_fifo_tb_top.sv
module sertx_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ch_enable = 1'b1, idle_mode = 1'b0, idle_keep_run = 1'b0, full_duplex = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        pop_req = 1'b0;
    logic [7:0]  hold_data;
    logic        hold_full;
    logic [2:0]  tx_level;
    logic        overrun, tx_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sertx_fifo dut_i (
        .clk(clk), .rst(rst), .ch_enable(ch_enable), .idle_mode(idle_mode),
        .idle_keep_run(idle_keep_run), .full_duplex(full_duplex),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
        .hold_data(hold_data), .hold_full(hold_full), .tx_level(tx_level),
        .overrun(overrun), .tx_irq(tx_irq)
    );

    // Behavioural reference model
    logic [7:0] mq[$];
    logic [7:0] m_hold = 0;
    bit m_hf = 0, m_ovr = 0, m_irq = 0, m_cmp = 0;
    int m_code = 0;

    function automatic bit met(int lvl, bit cmp, int code, bit fdx);
        int t;
        t = fdx ? (code % 2) : code;
        return cmp ? (lvl <= t) : (lvl == t);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mq.delete(); m_hold = 0; m_hf = 0; m_ovr = 0; m_irq = 0; m_cmp = 0; m_code = 0;
        end else begin
            bit live, w, qc, bc, ev, dpop, dpush;
            int cap, oldl;
            live = ch_enable && !(idle_mode && !idle_keep_run);
            w  = reg_wr && live;
            qc = w && reg_wdata[7];
            bc = w && reg_wdata[8];
            cap = full_duplex ? 2 : 4;
            oldl = mq.size();
            ev = 0;
            if (qc) begin
                mq.delete(); m_ovr = 0; ev = 1;
            end else begin
                dpop  = pop_req && !bc && oldl > 0;
                dpush = push_valid && oldl < cap;
                if (push_valid && !dpush) m_ovr = 1;
                if (dpop) begin m_hold = mq.pop_front(); m_hf = 1; end
                if (dpush) mq.push_back(push_data);
                ev = dpop || dpush;
            end
            if (bc) begin m_hold = 0; m_hf = 0; end
            m_irq = ev && met(mq.size(), m_cmp, m_code, full_duplex) && !met(oldl, m_cmp, m_code, full_duplex);
            if (!live) begin m_cmp = 0; m_code = 0; end
            else if (w) begin m_cmp = reg_wdata[6]; m_code = int'(reg_wdata[1:0]); end
        end
    end

    task automatic chk(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle compare, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(tx_level, mq.size(), "R4 level");
            chk(hold_data, m_hold, "R4 hold_data");
            chk(hold_full, m_hf, "R3 hold_full");
            chk(overrun, m_ovr, "R5 overrun");
            chk(tx_irq, m_irq, "R10 irq");
            chk(reg_rdata, {23'b0, 2'b00, m_cmp, 4'b0, 2'(m_code)}, "R1 rdata");
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1; reg_wdata = d; tick(); reg_wr = 0;
    endtask

    task automatic push(input logic [7:0] d);
        push_valid = 1; push_data = d; tick(); push_valid = 0;
    endtask

    task automatic pop();
        pop_req = 1; tick(); pop_req = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk(tx_level, 0, "R4 reset level");
        chk(reg_rdata, 0, "R1 reset rdata");
        chk(tx_irq, 0, "R10 reset irq");

        // R1 readback layout
        wr(32'hFFFF_FFFF);
        chk(reg_rdata, 32'h43, "R1 all-ones write");
        wr(32'h0000_0001);
        chk(reg_rdata, 32'h1, "R1 code only");
        // R2 zero in command bits does nothing
        push(8'h11); push(8'h12);
        wr(32'h41);
        chk(tx_level, 2, "R2 zero clear bit keeps queue");
        wr(32'h80);
        chk(tx_level, 0, "R2 clear empties");

        // R4 R5 R6 half-duplex order and capacity
        push(8'hA1); push(8'hA2); push(8'hA3); push(8'hA4);
        chk(tx_level, 4, "R5 half capacity");
        push(8'hA5);
        chk(tx_level, 4, "R5 push when full dropped");
        chk(overrun, 1, "R5 overrun set");
        pop();
        chk(hold_data, 8'hA1, "R4 first out");
        chk(tx_level, 3, "R4 level after pop");
        pop(); pop(); pop();
        chk(hold_data, 8'hA4, "R4 last out");
        pop();
        chk(hold_data, 8'hA4, "R6 empty pop keeps data");
        chk(tx_level, 0, "R6 empty pop keeps level");
        chk(overrun, 1, "R5 overrun sticky");
        wr(32'h80);
        chk(overrun, 0, "R2 clear drops overrun");

        // R2 clear with simultaneous push
        push(8'hB1); push(8'hB2);
        push_valid = 1; push_data = 8'hB3; wr(32'h80); push_valid = 0;
        chk(tx_level, 0, "R2 clear beats push");
        push(8'hB4); pop();
        chk(hold_data, 8'hB4, "R2 pointers reset");

        // R3 holding buffer clear
        wr(32'h80);
        push(8'hC1); push(8'hC2); pop();
        chk(hold_full, 1, "R3 hold loaded");
        wr(32'h100);
        chk(hold_full, 0, "R3 buffer clear flag");
        chk(hold_data, 0, "R3 buffer clear data");
        chk(tx_level, 1, "R3 queue untouched");
        pop_req = 1; wr(32'h100); pop_req = 0;
        chk(tx_level, 1, "R3 pop ignored with buffer clear");

        // R7 half-duplex equal compare
        wr(32'h82);
        push(8'h01);
        chk(tx_irq, 0, "R7 level1 vs thr2");
        push(8'h02);
        chk(tx_irq, 1, "R7 level2 hits thr2");
        tick();
        chk(tx_irq, 0, "R10 single pulse");
        push(8'h03);
        chk(tx_irq, 0, "R7 level3 misses thr2");
        pop();
        chk(tx_irq, 1, "R7 back to 2");
        wr(32'h03);
        push(8'h04);
        chk(tx_irq, 1, "R7 thr3");

        // R9 at-or-below compare
        wr(32'hC1);
        push(8'h05);
        chk(tx_irq, 0, "R9 already met at 0");
        push(8'h06); push(8'h07);
        pop(); chk(tx_irq, 0, "R9 2 above 1");
        pop(); chk(tx_irq, 1, "R9 1 at-or-below 1");
        pop(); chk(tx_irq, 0, "R10 no repeat while true");

        // R8 full-duplex decode
        full_duplex = 1;
        wr(32'h82);
        push(8'h08);
        chk(tx_irq, 0, "R8 code2 means empty");
        pop();
        chk(tx_irq, 1, "R8 reach empty");
        wr(32'h03);
        push(8'h09);
        chk(tx_irq, 1, "R8 code3 means one");
        push(8'h0A); push(8'h0B);
        chk(tx_level, 2, "R5 full capacity");
        chk(overrun, 1, "R5 full overrun");
        wr(32'h80);
        full_duplex = 0;

        // R12 simultaneous push and pop
        push(8'hD1);
        push_valid = 1; push_data = 8'hD2; pop(); push_valid = 0;
        chk(tx_level, 1, "R12 level unchanged");
        chk(hold_data, 8'hD1, "R12 head moved");
        pop();
        chk(hold_data, 8'hD2, "R12 pushed byte kept");

        // R11 configuration reset conditions
        wr(32'h42);
        ch_enable = 0; tick();
        chk(reg_rdata, 0, "R11 disabled resets");
        wr(32'h43);
        chk(reg_rdata, 0, "R11 write ignored");
        ch_enable = 1;
        wr(32'h42);
        idle_mode = 1; idle_keep_run = 1; tick();
        chk(reg_rdata, 32'h42, "R11 idle with run kept");
        idle_keep_run = 0; tick();
        chk(reg_rdata, 0, "R11 idle without run resets");
        idle_mode = 0; tick();

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            push_valid = r[0];
            push_data  = r[15:8];
            pop_req    = r[1] & r[2];
            reg_wr     = (r[7:3] == 5'd0);
            reg_wdata  = {23'b0, r[20], r[21] & r[22], r[23], 4'b0, r[25:24]};
            if (r[30:26] == 5'd0) full_duplex = ~full_duplex;
            ch_enable  = (r[31:28] != 4'd0);
            tick();
        end
        push_valid = 0; pop_req = 0; reg_wr = 0; ch_enable = 1;
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule